// File: doc/BRIEF.md
# Lives and Timer Game Controller

This block is the top-level state machine of a single-player platform game. It keeps the player's remaining lives, a countdown of the seconds left and the score. It passes all three to the display logic, together with the current game state. Collision logic, a one-second tick and a frame tick reach it as single-cycle pulses. It turns them into the progress of the game: a bomb hit costs a life unless the invincibility switch is on, and collecting a gem adds points. The game ends when the last life is gone or the countdown runs out.

A hit is followed by a short grace period, counted in frames, during which further bombs do nothing and the clock is held. When the game is over, a restart press reloads lives, time and score and returns to the waiting state. A start or restart press then begins a new game. All inputs are synchronous to the clock, and reset is active low. Every output is a plain status pin. No stream passes through the block, so there is no valid/ready handshake and no back-pressure.

Top module: `gc_game_ctrl`

## Requirements
- R1: While reset is low and after it is released, the state is IDLE (code 0), lives are 3, time is 99 and score is 0.
- R2: In IDLE, a start or restart pulse moves the state to PLAY (code 1) on the next cycle.
- R3: In PLAY, a bomb pulse with god mode low lowers lives by one on the next cycle and, if lives remain, enters HIT (code 2).
- R4: In PLAY, a bomb pulse with god mode high changes neither lives nor state.
- R5: In HIT, bomb pulses are ignored, and the state returns to PLAY on the cycle after the 64th frame tick counted since HIT was entered.
- R6: The time output falls by one on each one-second tick in PLAY and holds its value in IDLE, HIT and GAME_OVER.
- R7: A bomb that takes the last life moves the state to GAME_OVER (code 3), with lives at 0.
- R8: A tick that takes the time from 1 to 0 in PLAY moves the state to GAME_OVER, and lives are left unchanged.
- R9: When a last-life bomb and the final tick fall in the same cycle, the state goes to GAME_OVER with lives 0 and time 0. The life is taken only once.
- R10: A gem pulse in PLAY or HIT adds 100 to the score, which saturates at 9999. In IDLE and GAME_OVER a gem has no effect.
- R11: In GAME_OVER a start pulse is ignored. A restart pulse returns to IDLE with lives 3, time 99 and score 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Start press pulse |
| restart_i | input | 1 | Restart press pulse |
| bomb_i | input | 1 | Player touched a bomb, one-cycle pulse |
| god_mode_i | input | 1 | Invincibility switch, level |
| gem_i | input | 1 | Player collected a gem, one-cycle pulse |
| sec_tick_i | input | 1 | One-second tick pulse |
| frame_tick_i | input | 1 | Frame tick pulse |
| state_o | output | 2 | Game state: 0 IDLE, 1 PLAY, 2 HIT, 3 GAME_OVER |
| lives_o | output | 2 | Remaining lives |
| time_o | output | 7 | Remaining seconds |
| score_o | output | 14 | Score |

## Verification
The two functions that can fall in the same cycle are the loss of the last life and the expiry of the countdown. Both end the game. To provoke the collision, the bench first spends two lives, each followed by a full grace period. It then ticks the timer down to 1 and drives a bomb and a second tick together. The expected result is GAME_OVER with lives and time both at zero, which shows that the life was taken exactly once. Each end condition is also driven on its own, and the sweeps of the timer and the score check every step against values computed arithmetically in the bench.

// File: rtl/gc_pkg.sv
package gc_pkg;
  typedef enum logic [1:0] {
    GC_IDLE = 2'd0,
    GC_PLAY = 2'd1,
    GC_HIT  = 2'd2,
    GC_OVER = 2'd3
  } gc_state_e;
endpackage

// File: rtl/gc_down_counter.sv
// Loadable down counter: reset and load put INIT in, dec removes one.
module gc_down_counter #(
  parameter int INIT = 3,
  parameter int W    = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic         dec,
  output logic [W-1:0] value
);
  localparam logic [W-1:0] START = W'(INIT);

  always_ff @(posedge clk) begin
    if (!rst_n || load) value <= START;
    else if (dec && value != '0) value <= value - W'(1);
  end
endmodule

// File: rtl/gc_grace.sv
// Counts frame ticks while in the hit state; flags the last one.
module gc_grace #(
  parameter int FRAMES = 64
) (
  input  logic clk,
  input  logic rst_n,
  input  logic in_hit,
  input  logic frame_tick,
  output logic done
);
  localparam int CW = $clog2(FRAMES + 1);
  localparam logic [CW-1:0] LAST = CW'(FRAMES - 1);

  logic [CW-1:0] cnt;

  assign done = in_hit && frame_tick && (cnt == LAST);

  always_ff @(posedge clk) begin
    if (!rst_n || !in_hit) cnt <= '0;
    else if (frame_tick && !done) cnt <= cnt + CW'(1);
  end
endmodule

// File: rtl/gc_score.sv
// Saturating score accumulator.
module gc_score #(
  parameter int STEP = 100,
  parameter int MAXV = 9999,
  parameter int W    = 14
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         add,
  output logic [W-1:0] score
);
  localparam logic [W:0] STEP_V = (W+1)'(STEP);
  localparam logic [W:0] MAX_V  = (W+1)'(MAXV);

  logic [W:0] sum;
  assign sum = {1'b0, score} + STEP_V;

  always_ff @(posedge clk) begin
    if (!rst_n || clr) score <= '0;
    else if (add) score <= (sum > MAX_V) ? MAX_V[W-1:0] : sum[W-1:0];
  end
endmodule

// File: rtl/gc_fsm.sv
// Game state register and event qualification.
module gc_fsm
  import gc_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      start,
  input  logic      restart,
  input  logic      bomb,
  input  logic      god_mode,
  input  logic      sec_tick,
  input  logic      gem,
  input  logic      last_life,
  input  logic      last_second,
  input  logic      grace_done,
  output gc_state_e state,
  output logic      strike,
  output logic      run_tick,
  output logic      score_add,
  output logic      reload
);
  gc_state_e nxt;
  logic      expire;

  assign strike    = (state == GC_PLAY) && bomb && !god_mode;
  assign run_tick  = (state == GC_PLAY) && sec_tick;
  assign expire    = run_tick && last_second;
  assign score_add = gem && ((state == GC_PLAY) || (state == GC_HIT));
  assign reload    = (state == GC_OVER) && restart;

  always_comb begin
    nxt = state;
    unique case (state)
      GC_IDLE: if (start || restart) nxt = GC_PLAY;
      GC_PLAY: begin
        if (expire || (strike && last_life)) nxt = GC_OVER;
        else if (strike)                     nxt = GC_HIT;
      end
      GC_HIT:  if (grace_done) nxt = GC_PLAY;
      GC_OVER: if (restart) nxt = GC_IDLE;
      default: nxt = GC_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) state <= GC_IDLE;
    else        state <= nxt;
  end
endmodule

// File: rtl/gc_game_ctrl.sv
module gc_game_ctrl
  import gc_pkg::*;
#(
  parameter int LIVES_INIT   = 3,
  parameter int TIME_INIT    = 99,
  parameter int GRACE_FRAMES = 64,
  parameter int GEM_POINTS   = 100,
  parameter int SCORE_MAX    = 9999,
  localparam int LW = $clog2(LIVES_INIT + 1),
  localparam int TW = $clog2(TIME_INIT + 1),
  localparam int SW = $clog2(SCORE_MAX + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start_i,
  input  logic          restart_i,
  input  logic          bomb_i,
  input  logic          god_mode_i,
  input  logic          gem_i,
  input  logic          sec_tick_i,
  input  logic          frame_tick_i,
  output logic [1:0]    state_o,
  output logic [LW-1:0] lives_o,
  output logic [TW-1:0] time_o,
  output logic [SW-1:0] score_o
);
  gc_state_e st;
  logic strike, run_tick, score_add, reload, grace_done;

  gc_fsm u_fsm (
    .clk(clk), .rst_n(rst_n), .start(start_i), .restart(restart_i),
    .bomb(bomb_i), .god_mode(god_mode_i), .sec_tick(sec_tick_i), .gem(gem_i),
    .last_life(lives_o == LW'(1)), .last_second(time_o == TW'(1)),
    .grace_done(grace_done), .state(st), .strike(strike),
    .run_tick(run_tick), .score_add(score_add), .reload(reload)
  );

  gc_down_counter #(.INIT(LIVES_INIT), .W(LW)) u_lives (
    .clk(clk), .rst_n(rst_n), .load(reload), .dec(strike), .value(lives_o)
  );

  gc_down_counter #(.INIT(TIME_INIT), .W(TW)) u_timer (
    .clk(clk), .rst_n(rst_n), .load(reload), .dec(run_tick), .value(time_o)
  );

  gc_grace #(.FRAMES(GRACE_FRAMES)) u_grace (
    .clk(clk), .rst_n(rst_n), .in_hit(st == GC_HIT),
    .frame_tick(frame_tick_i), .done(grace_done)
  );

  gc_score #(.STEP(GEM_POINTS), .MAXV(SCORE_MAX), .W(SW)) u_score (
    .clk(clk), .rst_n(rst_n), .clr(reload), .add(score_add), .score(score_o)
  );

  assign state_o = st;
endmodule

// File: rtl/gc_game_ctrl_chk.sv
module gc_game_ctrl_chk #(
  parameter int SCORE_MAX = 9999,
  parameter int LW = 2,
  parameter int TW = 7,
  parameter int SW = 14
) (
  input logic          clk,
  input logic          rst_n,
  input logic          start_i,
  input logic          restart_i,
  input logic          bomb_i,
  input logic          god_mode_i,
  input logic          gem_i,
  input logic [1:0]    state_o,
  input logic [LW-1:0] lives_o,
  input logic [TW-1:0] time_o,
  input logic [SW-1:0] score_o
);
  p_idle_start_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (state_o == 2'd0 && (start_i || restart_i)) |=> state_o == 2'd1);

  p_bomb_life_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (state_o == 2'd1 && bomb_i && !god_mode_i) |=> lives_o == $past(lives_o) - LW'(1));

  p_god_keep_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (state_o == 2'd1 && bomb_i && god_mode_i) |=> $stable(lives_o));

  p_hit_ignore_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (state_o == 2'd2) |=> $stable(lives_o));

  p_hit_frozen_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (state_o == 2'd2) |=> $stable(time_o));

  p_over_cause_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (state_o == 2'd3) |-> (lives_o == '0 || time_o == '0));

  p_score_cap_r10: assert property (@(posedge clk) disable iff (!rst_n)
    32'(score_o) <= SCORE_MAX);

  p_idle_gem_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (state_o == 2'd0 && gem_i && !start_i && !restart_i) |=> $stable(score_o));

  p_over_start_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (state_o == 2'd3 && start_i && !restart_i) |=> state_o == 2'd3);
endmodule

bind gc_game_ctrl gc_game_ctrl_chk #(
  .SCORE_MAX(SCORE_MAX), .LW(LW), .TW(TW), .SW(SW)
) u_chk (
  .clk(clk), .rst_n(rst_n), .start_i(start_i), .restart_i(restart_i),
  .bomb_i(bomb_i), .god_mode_i(god_mode_i), .gem_i(gem_i),
  .state_o(state_o), .lives_o(lives_o), .time_o(time_o), .score_o(score_o)
);

// File: tb/sim_gc_game_ctrl.sv
`timescale 1ns/1ps
module sim_gc_game_ctrl;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start_i = 0, restart_i = 0, bomb_i = 0, god_mode_i = 0;
  logic gem_i = 0, sec_tick_i = 0, frame_tick_i = 0;
  logic [1:0]  state_o;
  logic [1:0]  lives_o;
  logic [6:0]  time_o;
  logic [13:0] score_o;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  int exp_score = 0;
  int exp_time = 0;

  always #4 clk = ~clk;

  gc_game_ctrl u0 (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .restart_i(restart_i),
    .bomb_i(bomb_i), .god_mode_i(god_mode_i), .gem_i(gem_i),
    .sec_tick_i(sec_tick_i), .frame_tick_i(frame_tick_i),
    .state_o(state_o), .lives_o(lives_o), .time_o(time_o), .score_o(score_o)
  );

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", tag, act, exp);
    end
  endtask

  // One cycle of stimulus, applied at a falling edge; outputs are settled on return.
  task automatic cyc(input logic st, input logic rs, input logic bm,
                     input logic gm, input logic sc, input logic fr);
    @(negedge clk);
    start_i = st; restart_i = rs; bomb_i = bm; gem_i = gm;
    sec_tick_i = sc; frame_tick_i = fr;
    @(negedge clk);
    start_i = 0; restart_i = 0; bomb_i = 0; gem_i = 0;
    sec_tick_i = 0; frame_tick_i = 0;
  endtask

  task automatic grace_out();
    for (int k = 1; k <= 64; k++) begin
      cyc(0, 0, 0, 0, 0, 1);
      if (k == 63) chk("R5 still HIT after 63 frames", int'(state_o), 2);
    end
    chk("R5 back to PLAY after 64 frames", int'(state_o), 1);
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      errors++;
      $display("FAIL watchdog actual %0d expected %0d", cycles, 100000);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 state in reset", int'(state_o), 0);
    chk("R1 lives in reset", int'(lives_o), 3);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 state", int'(state_o), 0);
    chk("R1 lives", int'(lives_o), 3);
    chk("R1 time", int'(time_o), 99);
    chk("R1 score", int'(score_o), 0);

    // Inputs in IDLE other than start/restart do nothing.
    cyc(0, 0, 1, 1, 1, 1);
    chk("R10 gem ignored in IDLE", int'(score_o), 0);
    chk("R6 time held in IDLE", int'(time_o), 99);
    chk("R2 stays IDLE", int'(state_o), 0);

    cyc(1, 0, 0, 0, 0, 0);
    chk("R2 start to PLAY", int'(state_o), 1);

    exp_time = 99;
    for (int k = 0; k < 5; k++) begin
      cyc(0, 0, 0, 0, 1, 0);
      exp_time--;
      chk("R6 tick in PLAY", int'(time_o), exp_time);
    end

    god_mode_i = 1;
    cyc(0, 0, 1, 0, 0, 0);
    chk("R4 god lives", int'(lives_o), 3);
    chk("R4 god state", int'(state_o), 1);
    god_mode_i = 0;

    cyc(0, 0, 1, 0, 0, 0);
    chk("R3 lives after bomb", int'(lives_o), 2);
    chk("R3 state HIT", int'(state_o), 2);
    cyc(0, 0, 0, 0, 1, 0);
    chk("R6 time held in HIT", int'(time_o), exp_time);
    cyc(0, 0, 1, 0, 0, 0);
    chk("R5 bomb ignored in HIT", int'(lives_o), 2);
    cyc(0, 0, 0, 1, 0, 0);
    exp_score = 100;
    chk("R10 gem in HIT", int'(score_o), exp_score);
    grace_out();

    // Score sweep to saturation.
    for (int k = 0; k < 101; k++) begin
      cyc(0, 0, 0, 1, 0, 0);
      exp_score = (exp_score + 100 > 9999) ? 9999 : exp_score + 100;
      chk("R10 score step", int'(score_o), exp_score);
    end

    cyc(0, 0, 1, 0, 0, 0);
    chk("R3 second bomb", int'(lives_o), 1);
    grace_out();
    cyc(0, 0, 1, 0, 0, 0);
    chk("R7 state OVER", int'(state_o), 3);
    chk("R7 lives zero", int'(lives_o), 0);

    cyc(1, 0, 0, 1, 1, 0);
    chk("R11 start ignored in OVER", int'(state_o), 3);
    chk("R10 gem ignored in OVER", int'(score_o), 9999);
    chk("R6 time held in OVER", int'(time_o), exp_time);
    cyc(0, 1, 0, 0, 0, 0);
    chk("R11 restart to IDLE", int'(state_o), 0);
    chk("R11 lives reloaded", int'(lives_o), 3);
    chk("R11 time reloaded", int'(time_o), 99);
    chk("R11 score cleared", int'(score_o), 0);

    // Coincidence: last life and last second together.
    cyc(0, 1, 0, 0, 0, 0);
    chk("R2 restart to PLAY", int'(state_o), 1);
    cyc(0, 0, 1, 0, 0, 0);
    grace_out();
    cyc(0, 0, 1, 0, 0, 0);
    grace_out();
    chk("R9 setup lives", int'(lives_o), 1);
    for (int k = 0; k < 98; k++) cyc(0, 0, 0, 0, 1, 0);
    chk("R9 setup time", int'(time_o), 1);
    chk("R9 setup state", int'(state_o), 1);
    cyc(0, 0, 1, 0, 1, 0);
    chk("R9 state OVER", int'(state_o), 3);
    chk("R9 lives once", int'(lives_o), 0);
    chk("R9 time zero", int'(time_o), 0);

    // Expiry alone.
    cyc(0, 1, 0, 0, 0, 0);
    cyc(1, 0, 0, 0, 0, 0);
    exp_time = 99;
    for (int k = 0; k < 99; k++) begin
      cyc(0, 0, 0, 0, 1, 0);
      exp_time--;
      chk("R8 countdown", int'(time_o), exp_time);
      if (k == 97) chk("R8 still PLAY at 1", int'(state_o), 1);
    end
    chk("R8 state OVER", int'(state_o), 3);
    chk("R8 lives kept", int'(lives_o), 3);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule